// File: doc/BRIEF.md
# I2C Slave Shared-Buffer Interface

This block lets an external I2C master read and write a small on-chip byte buffer, while a local processor reads and writes the same bytes through its own synchronous port. The two sides do not coordinate in hardware: each behaves as if it owned one port of a dual-port memory. Any handshaking between the master and the processor is left to software conventions kept inside the buffer contents.

The slave answers one 7-bit bus address. The master reaches the buffer through a pair of pointers. The first data byte of each bus write loads the pointer pair and is not stored. Every later written byte is stored at the current pointer, and every byte read comes from the current pointer. Each start or repeated start rewinds the current pointer to the base pointer, so repeated reads begin at the same place until a new write moves the base. Locations beyond the buffer absorb writes without effect and read back as filler.

SCL and SDA are sampled in the system clock domain. SDA is driven open-drain through an output enable. The slave never stretches the clock.

Top module: `i2c_shared_buffer`

## Requirements
- R1: A header byte is sent address MSB first and followed by the direction bit, where 1 means read. The slave pulls SDA low in the acknowledge slot only when the 7 header address bits equal SLAVE_ADDR. For any other address it leaves SDA released in the acknowledge slot, stays off the bus until the next start, and stores nothing.
- R2: In a bus write, the first data byte after the header loads both the base pointer and the current pointer. That byte is acknowledged and is not written into the buffer.
- R3: Each further byte of a bus write is acknowledged, is stored at the current pointer, and then advances the current pointer by one. The current pointer is 8 bits wide and stops at 0xFF.
- R4: In a bus read, bytes are returned MSB first starting at the current pointer, which advances by one after each byte. A master ACK (SDA low) asks for the next byte. A master NACK ends the transfer.
- R5: Every start or repeated start sets the current pointer back to the base pointer. The base pointer changes only through the pointer byte of a write, so successive reads, with or without a stop in between, begin at the same location.
- R6: A written byte whose current pointer is at or above DEPTH (32) is acknowledged and then discarded. No buffer location changes.
- R7: A read byte whose current pointer is at or above DEPTH returns 0xFF.
- R8: The processor port writes cpu_wdata to cpu_addr in a cycle with cpu_en=1 and cpu_we=1. In a cycle with cpu_en=1 and cpu_we=0 it reads cpu_addr, and the data appears on cpu_rdata in the following cycle.
- R9: When the processor port and the bus side need the buffer in the same cycle, the processor access proceeds first and the bus access is held until a cycle with cpu_en=0. Bus data is unaffected as long as such a cycle occurs within the SCL low phase.
- R10: After reset SDA is released (sda_oe=0) and both pointers are 0, so a read issued before any write starts at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W (5) | Processor buffer address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, one cycle after the strobe |

## Verification
On every cycle, assertions check the following: the base pointer moves only when a pointer byte is taken; each start leaves the current pointer equal to the base; a bus write request is never raised for an out-of-range pointer; and a waiting bus request holds still while the processor owns the buffer. Only the bench scenarios can show the rest. These are address matching and the acknowledge levels on the wire, the actual buffer contents after in-range and out-of-range writes, filler on reads past the end, the rewind on repeated reads, and correct data under steady processor contention, all compared against a bench model of the buffer and pointers.

// File: rtl/i2c_shbuf_pkg.sv
package i2c_shbuf_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } shb_state_e;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == {PTR_W{1'b1}}) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_shbuf_sync.sv
module i2c_shbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] prev_d, prev_q;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], line_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign line_s[g] = pipe_q[STAGES-1];
    end

    always_comb begin
        prev_d = line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    logic scl_s, scl_p, sda_p;
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];
    assign scl_p = prev_q[0];
    assign sda_p = prev_q[1];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_shbuf_mem.sv
module i2c_shbuf_mem #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              i2c_req,
    input  logic              i2c_we,
    input  logic [ADDR_W-1:0] i2c_addr,
    input  logic [7:0]        i2c_wdata,
    output logic              i2c_gnt,
    output logic              i2c_rvalid,
    output logic [7:0]        i2c_rdata
);

    typedef struct packed {
        logic [7:0] cpu_rd;
        logic [7:0] bus_rd;
        logic       bus_vld;
    } mem_regs_t;

    mem_regs_t  r_d, r_q;
    logic [7:0] store [DEPTH];

    // processor wins every shared cycle
    assign i2c_gnt = i2c_req & ~cpu_en;

    always_comb begin
        r_d         = r_q;
        r_d.bus_vld = i2c_gnt & ~i2c_we;
        if (cpu_en && !cpu_we)   r_d.cpu_rd = store[cpu_addr];
        if (i2c_gnt && !i2c_we)  r_d.bus_rd = store[i2c_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (cpu_en && cpu_we)        store[cpu_addr] <= cpu_wdata;
        else if (i2c_gnt && i2c_we)  store[i2c_addr] <= i2c_wdata;
    end

    assign cpu_rdata  = r_q.cpu_rd;
    assign i2c_rdata  = r_q.bus_rd;
    assign i2c_rvalid = r_q.bus_vld;

endmodule

// File: rtl/i2c_shbuf_engine.sv
module i2c_shbuf_engine
    import i2c_shbuf_pkg::*;
#(
    parameter int         DEPTH      = 32,
    parameter int         ADDR_W     = $clog2(DEPTH),
    parameter logic [6:0] SLAVE_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              gnt,
    input  logic              rvalid,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic              req,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata
);

    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

    typedef struct packed {
        shb_state_e        st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              rw;
        logic              first;
        logic              mack;
        logic [PTR_W-1:0]  base;
        logic [PTR_W-1:0]  cur;
        logic [7:0]        txbuf;
        logic              req;
        logic              req_we;
        logic [ADDR_W-1:0] req_addr;
        logic [7:0]        req_wdata;
    } eng_regs_t;

    eng_regs_t r_d, r_q;
    logic [PTR_W-1:0] next_ptr;

    always_comb begin
        r_d      = r_q;
        next_ptr = ptr_step(r_q.cur);
        if (gnt)    r_d.req   = 1'b0;
        if (rvalid) r_d.txbuf = rdata;

        if (bus_stop) begin
            r_d.st = ST_IDLE;
        end else if (bus_start) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.cur = r_q.base;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        if (r_q.sh[7:1] == SLAVE_ADDR) begin
                            r_d.st    = ST_AACK;
                            r_d.rw    = r_q.sh[0];
                            r_d.first = 1'b1;
                            if (r_q.sh[0]) begin
                                if (r_q.cur < LIMIT) begin
                                    r_d.req      = 1'b1;
                                    r_d.req_we   = 1'b0;
                                    r_d.req_addr = r_q.cur[ADDR_W-1:0];
                                end else begin
                                    r_d.txbuf = 8'hFF;
                                end
                            end
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.st = ST_RDATA;
                            r_d.sh = r_q.txbuf;
                        end else begin
                            r_d.st = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.st = ST_WACK;
                        if (r_q.first) begin
                            r_d.base  = r_q.sh;
                            r_d.cur   = r_q.sh;
                            r_d.first = 1'b0;
                        end else begin
                            if (r_q.cur < LIMIT) begin
                                r_d.req       = 1'b1;
                                r_d.req_we    = 1'b1;
                                r_d.req_addr  = r_q.cur[ADDR_W-1:0];
                                r_d.req_wdata = r_q.sh;
                            end
                            r_d.cur = next_ptr;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        r_d.st  = ST_WDATA;
                        r_d.cnt = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.st  = ST_RACK;
                            r_d.cur = next_ptr;
                            if (next_ptr < LIMIT) begin
                                r_d.req      = 1'b1;
                                r_d.req_we   = 1'b0;
                                r_d.req_addr = next_ptr[ADDR_W-1:0];
                            end else begin
                                r_d.txbuf = 8'hFF;
                            end
                        end else begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st  = ST_RDATA;
                            r_d.sh  = r_q.txbuf;
                            r_d.cnt = '0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe    = (r_q.st == ST_AACK) || (r_q.st == ST_WACK) ||
                       ((r_q.st == ST_RDATA) && !r_q.sh[7]);
    assign req       = r_q.req;
    assign req_we    = r_q.req_we;
    assign req_addr  = r_q.req_addr;
    assign req_wdata = r_q.req_wdata;

    // base pointer moves only when a pointer byte has just been taken
    assert_base_only_on_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.base) |-> (r_q.st == ST_WACK && !r_q.first));

    // a start rewinds the current pointer to the base
    assert_start_rewinds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (r_q.cur == r_q.base));

    // a freshly raised bus write always came from an in-range pointer
    assert_no_oob_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !$past(r_q.req) && r_q.req_we) |-> ($past(r_q.cur) < LIMIT));

    // a waiting bus access holds still while the processor owns the buffer
    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !gnt) |=> (r_q.req && $stable(r_q.req_addr) && $stable(r_q.req_we)));

endmodule

// File: rtl/i2c_shared_buffer.sv
module i2c_shared_buffer #(
    parameter int         DEPTH       = 32,
    parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
    parameter int         SYNC_STAGES = 2,
    localparam int        ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata
);

    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              req, req_we, gnt, rvalid;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_wdata, rdata;

    i2c_shbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_shbuf_engine #(
        .DEPTH      (DEPTH),
        .ADDR_W     (ADDR_W),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .gnt       (gnt),
        .rvalid    (rvalid),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    i2c_shbuf_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_en     (cpu_en),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .i2c_req    (req),
        .i2c_we     (req_we),
        .i2c_addr   (req_addr),
        .i2c_wdata  (req_wdata),
        .i2c_gnt    (gnt),
        .i2c_rvalid (rvalid),
        .i2c_rdata  (rdata)
    );

endmodule

// File: tb/i2c_shared_buffer_tb_top.sv
`timescale 1ns/1ps
module i2c_shared_buffer_tb_top;

    localparam int         DEPTH = 32;
    localparam int         AW    = 5;
    localparam logic [6:0] SADDR = 7'h3A;
    localparam int         Q     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic          sda_line;
    logic          cpu_en = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] model [DEPTH];
    logic [7:0] base_m = 8'h00;
    logic [7:0] cur_m  = 8'h00;
    logic [7:0] wbuf [8];
    bit         hammer_on = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_shared_buffer #(.DEPTH(DEPTH), .SLAVE_ADDR(SADDR)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .cpu_en    (cpu_en),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata)
    );

    function automatic logic [7:0] step_m(input logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

    function automatic logic [7:0] expect_rd(input logic [7:0] p);
        return (p < DEPTH) ? model[p[AW-1:0]] : 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit more, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line; wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = more ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    // bus write: pointer byte then n data bytes from wbuf
    task automatic bus_write(input logic [7:0] ptr, input int n, input bit stop);
        logic ack;
        bus_start();
        cur_m = base_m;
        send_byte({SADDR, 1'b0}, ack);
        chk("R1 header ack", ack, 0);
        send_byte(ptr, ack);
        chk("R2 pointer ack", ack, 0);
        base_m = ptr;
        cur_m  = ptr;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk((cur_m < DEPTH) ? "R3 data ack" : "R6 discard ack", ack, 0);
            if (cur_m < DEPTH) model[cur_m[AW-1:0]] = wbuf[i];
            cur_m = step_m(cur_m);
        end
        if (stop) bus_stop();
    endtask

    task automatic bus_read(input int n, input bit stop);
        logic       ack;
        logic [7:0] b;
        bus_start();
        cur_m = base_m;
        send_byte({SADDR, 1'b1}, ack);
        chk("R1 read header ack", ack, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk((cur_m < DEPTH) ? "R4 R5 read data" : "R7 filler", b, expect_rd(cur_m));
            cur_m = step_m(cur_m);
        end
        if (stop) bus_stop();
    endtask

    task automatic cpu_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_en = 1'b0; cpu_we = 1'b0;
        model[a] = d;
    endtask

    task automatic cpu_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_en = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic verify_all(input string tag);
        logic [7:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            cpu_read(AW'(a), d);
            chk(tag, d, model[a]);
        end
    endtask

    // processor holds the buffer 5 of every 7 cycles, reading location 31
    task automatic hammer();
        while (hammer_on) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = 5'd31;
            end
            @(negedge clk);
            cpu_en = 1'b0;
            chk("R9 R8 cpu read under contention", cpu_rdata, model[31]);
            @(negedge clk);
        end
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        int         seed_v;
        seed_v = $urandom(32'd20240611);

        repeat (4) @(negedge clk);
        chk("R10 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 sda released after reset", sda_oe, 0);

        for (int a = 0; a < DEPTH; a++) cpu_write(AW'(a), 8'($urandom));
        verify_all("R8 cpu write then read");

        // pointers start at 0
        bus_read(2, 1'b1);

        // foreign address: NACK and nothing stored
        bus_start();
        send_byte({SADDR ^ 7'h01, 1'b0}, ack);
        chk("R1 foreign address nack", ack, 1);
        send_byte(8'h04, ack);
        chk("R1 off bus after nack", ack, 1);
        send_byte(8'h5A, ack);
        chk("R1 off bus after nack", ack, 1);
        bus_stop();
        verify_all("R1 storage untouched");

        // pointer byte loads pointers and is not stored
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        bus_write(8'd5, 3, 1'b1);
        cpu_read(5'd5, d);
        chk("R2 first data byte at pointer", d, 8'hA1);
        verify_all("R3 sequential store");
        bus_read(3, 1'b1);
        bus_read(2, 1'b1);

        // pointer only, then repeated start into a read; then read again without stop
        bus_write(8'd10, 0, 1'b0);
        bus_read(1, 1'b0);
        bus_read(2, 1'b1);

        // boundary: straddle the end
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        bus_write(8'd30, 4, 1'b1);
        verify_all("R6 writes past end dropped");
        bus_read(4, 1'b1);

        // far out of range pointer
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        bus_write(8'd200, 2, 1'b1);
        verify_all("R6 far pointer dropped");
        bus_read(2, 1'b1);

        // contention with the processor port
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        hammer_on = 1'b1;
        fork
            hammer();
            begin
                bus_write(8'd3, 4, 1'b1);
                bus_read(4, 1'b1);
                hammer_on = 1'b0;
            end
        join
        cpu_en = 1'b0;
        verify_all("R9 contention write landed");

        // constrained random transfers
        for (int it = 0; it < 12; it++) begin
            int n;
            logic [7:0] p;
            p = 8'($urandom_range(0, 40));
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            bus_write(p, n, 1'b1);
            if ($urandom_range(0, 1) == 1) cpu_write(5'($urandom_range(0, 31)), 8'($urandom));
            verify_all("R3 R6 random store");
            bus_read($urandom_range(1, 4), 1'b1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule